// File: doc/BRIEF.md
# SEU Event Timing Statistics Collector

This block times the phases of a soft-error scrubbing loop and keeps the most recent duration of each phase, so software can read them as raw clock counts. A scrub engine drives one-cycle strobes at the start of each scrub cycle and at the start and end of its detection and correction phases. An injection strobe with a two-bit timing option marks a deliberately planted error. An error poller drives strobes at the start of each poll and when a poll finds an error. The block also watches the level of the error output pin. Software turns a count into time by dividing it by the clock frequency. That conversion is outside the block.

Every measured value saturates one below all ones. The all-ones value is kept as a marker meaning "this phase has not happened yet". Software reads the values through a command/response mailbox. A read-statistics command names a sector. A monitored sector returns six words in a fixed order. A bad request returns one error word.

Top module: `seu_timing_stats`

## Requirements
- R1: The cycle word is the number of clocks between the two most recent scrub-cycle start strobes. It is updated at each start after the first.
- R2: The detect word is the number of clocks from a detect-start strobe to the following detect-end strobe.
- R3: The correct word is the number of clocks from a correct-start strobe to the following correct-end strobe. It reads all ones until the first correction completes.
- R4: The injection word counts clocks from an injection strobe to a detect-end strobe. The option sets which detect-end: code 2'b01 captures at the first detect-end after the injection, and code 2'b10 captures at the second. An injection with code 2'b00 or 2'b11 is ignored. The word reads all ones until the first capture.
- R5: The poll word is the number of clocks between the two most recent poll-start strobes.
- R6: The pin word is the number of clocks from an error-found strobe to the next change of level on the error pin input.
- R7: A measured duration saturates at all ones minus one (1022 for a 10-bit counter). It never equals the all-ones marker.
- R8: After reset, the cycle, detect, poll and pin words are zero, and the correct and injection words are all ones.
- R9: A command with opcode 0x40 whose sector (parameter bits starting at bit 16) is set in the monitored-sector mask is accepted while cmd_ready_o is high. It returns six words on six consecutive cycles, starting the cycle after acceptance. The order is cycle, detect, correct, injection, poll, pin. rsp_last_o is high on the sixth word. cmd_ready_o is low while words are being sent. The words are the values held at acceptance.
- R10: Any other opcode, or a sector whose mask bit is clear, returns a single word with data zero and with rsp_error_o and rsp_last_o both high.
- R11: An end strobe (detect, correct, pin change) with no open start leaves the held statistic unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_start_i | input | 1 | Scrub cycle start strobe |
| det_start_i | input | 1 | Detection phase start strobe |
| det_end_i | input | 1 | Detection phase end strobe |
| cor_start_i | input | 1 | Correction phase start strobe |
| cor_end_i | input | 1 | Correction phase end strobe |
| inj_i | input | 1 | Error injection strobe |
| inj_mode_i | input | 2 | Injection timing option, sampled with inj_i |
| poll_start_i | input | 1 | Error poll start strobe |
| err_found_i | input | 1 | Poll found an error |
| err_pin_i | input | 1 | Observed level of the error output pin |
| cmd_valid_i | input | 1 | Command present |
| cmd_opcode_i | input | 8 | Command opcode |
| cmd_param_i | input | 32 | Command parameter, sector at bit 16 |
| cmd_ready_o | output | 1 | Command can be accepted |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_data_o | output | CNT_W | Response word |
| rsp_last_o | output | 1 | Final word of a response |
| rsp_error_o | output | 1 | Request rejected |

## Verification
The assertions check several properties on every cycle. A running count never reaches the all-ones marker. A statistic holds its value in any cycle without a capture. An injection with an invalid option leaves the tracker idle. A response burst runs without gaps and ends after its last word. An error response is a single zero word. Only the bench's scenarios can show that each word equals the true gap between strobes, that each injection option picks the intended detect-end, that saturation lands exactly on the limit, and that the reset and ignored-strobe values reach the mailbox in the required order.

// File: rtl/seu_stats_pkg.sv
// Package: shared constants and types for the SEU timing statistics collector.
// Assumes: response word order is fixed and used by both mailbox and top.
package seu_stats_pkg;
    localparam logic [7:0] OPC_READ_STATS = 8'h40;
    localparam int         NUM_WORDS      = 6;
    localparam int         SECTOR_LSB     = 16;
    localparam logic [1:0] INJ_OPT_BEST   = 2'b01;
    localparam logic [1:0] INJ_OPT_WORST  = 2'b10;

    typedef enum logic [1:0] {
        INJ_IDLE  = 2'd0,
        INJ_SKIP  = 2'd1,
        INJ_ARMED = 2'd2
    } inj_state_e;
endpackage

// File: rtl/seu_span_timer.sv
// Module: seu_span_timer
// Measures the clock distance between two strobes and holds the latest value.
// PERIODIC=1: distance between successive start strobes (stop is unused).
// PERIODIC=0: distance from a start strobe to the next stop strobe; start wins
// when both arrive in the same cycle. The count saturates one below all ones.
// Assumes: strobes are single-cycle and synchronous to clk.
module seu_span_timer #(
    parameter int                 CNT_W    = 32,
    parameter bit                 PERIODIC = 1'b0,
    parameter logic [CNT_W-1:0]   RST_VAL  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] stat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {{(CNT_W-1){1'b1}}, 1'b0};
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] SENTINEL = '1;

    logic             running_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] stat_q;
    logic             capture;
    logic             close_run;

    // Pick the capture and close conditions for the chosen variant.
    generate
        if (PERIODIC) begin : g_periodic
            assign capture   = running_q && start_i;
            assign close_run = 1'b0;
        end else begin : g_span
            assign capture   = running_q && stop_i && !start_i;
            assign close_run = stop_i;
        end
    endgenerate

    // Run the saturating counter and latch it on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            stat_q    <= RST_VAL;
        end else begin
            if (start_i) begin
                running_q <= 1'b1;
                cnt_q     <= CNT_ONE;
            end else if (running_q) begin
                if (close_run) begin
                    running_q <= 1'b0;
                end else if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + CNT_ONE;
                end
            end
            if (capture) begin
                stat_q <= cnt_q;
            end
        end
    end

    assign stat_o = stat_q;

    // R7: a running count never reaches the marker value
    p_cnt_below_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (cnt_q != SENTINEL));

    // R7: a captured value is never the marker
    p_capture_not_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (stat_o != SENTINEL));

    // R11: without a capture the held value stays put
    p_hold_without_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(stat_o));
endmodule

// File: rtl/seu_inject_tracker.sv
// Module: seu_inject_tracker
// Times an injected error until the detect-end strobe picked by the timing
// option: best case = first detect-end, worst case = second detect-end.
// Other option codes are ignored. Holds all ones until the first capture.
// Assumes: a new valid injection restarts any measurement in progress.
module seu_inject_tracker
    import seu_stats_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inj_i,
    input  logic [1:0]       inj_mode_i,
    input  logic             det_end_i,
    output logic [CNT_W-1:0] stat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {{(CNT_W-1){1'b1}}, 1'b0};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    inj_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] stat_q;
    logic             inj_take;

    // Accept only the two defined option codes.
    assign inj_take = inj_i && ((inj_mode_i == INJ_OPT_BEST) || (inj_mode_i == INJ_OPT_WORST));

    // Step the tracker and count from the injection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INJ_IDLE;
            cnt_q   <= '0;
            stat_q  <= '1;
        end else if (inj_take) begin
            state_q <= (inj_mode_i == INJ_OPT_BEST) ? INJ_ARMED : INJ_SKIP;
            cnt_q   <= CNT_ONE;
        end else if (state_q != INJ_IDLE) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_ONE;
            end
            if (det_end_i) begin
                if (state_q == INJ_ARMED) begin
                    stat_q  <= cnt_q;
                    state_q <= INJ_IDLE;
                end else begin
                    state_q <= INJ_ARMED;
                end
            end
        end
    end

    assign stat_o = stat_q;

    // R4: while idle, anything but a valid injection leaves the tracker idle and the word unchanged
    p_idle_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == INJ_IDLE && !inj_take) |=> (state_q == INJ_IDLE && $stable(stat_o)));

    // R4: the skip state always advances to armed on a detect-end
    p_skip_then_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == INJ_SKIP && det_end_i && !inj_take) |=> (state_q == INJ_ARMED));

    // R7: a captured injection time is never the marker
    p_inj_not_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == INJ_ARMED && det_end_i && !inj_take) |=> (stat_o != '1));
endmodule

// File: rtl/seu_stats_mailbox.sv
// Module: seu_stats_mailbox
// Accepts one command at a time. A valid read snapshots all statistics and
// streams them one word per cycle. A bad opcode or unmonitored sector
// returns a single zero word flagged as an error.
// Assumes: the receiver takes every valid word (no back-pressure).
module seu_stats_mailbox
    import seu_stats_pkg::*;
#(
    parameter int                          CNT_W       = 32,
    parameter int                          SECTOR_W    = 4,
    parameter logic [(2**SECTOR_W)-1:0]    SECTOR_MASK = '1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_WORDS-1:0][CNT_W-1:0]   stats_i,
    input  logic                              cmd_valid_i,
    input  logic [7:0]                        cmd_opcode_i,
    input  logic [31:0]                       cmd_param_i,
    output logic                              cmd_ready_o,
    output logic                              rsp_valid_o,
    output logic [CNT_W-1:0]                  rsp_data_o,
    output logic                              rsp_last_o,
    output logic                              rsp_error_o
);
    localparam int                IDX_W    = $clog2(NUM_WORDS);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(NUM_WORDS - 1);
    localparam logic [IDX_W-1:0]  IDX_ONE  = IDX_W'(1);

    logic                            busy_q;
    logic                            err_q;
    logic [IDX_W-1:0]                idx_q;
    logic [NUM_WORDS-1:0][CNT_W-1:0] snap_q;
    logic [SECTOR_W-1:0]             sector;
    logic                            accept;
    logic                            req_ok;
    logic                            at_last;

    // Decode the request and the burst end.
    assign sector  = cmd_param_i[SECTOR_LSB +: SECTOR_W];
    assign req_ok  = (cmd_opcode_i == OPC_READ_STATS) && SECTOR_MASK[sector];
    assign accept  = cmd_valid_i && !busy_q;
    assign at_last = err_q || (idx_q == IDX_LAST);

    // Take a command, snapshot the statistics, then step through the words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            idx_q  <= '0;
            snap_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            err_q  <= !req_ok;
            idx_q  <= '0;
            snap_q <= stats_i;
        end else if (busy_q) begin
            if (at_last) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + IDX_ONE;
            end
        end
    end

    // Drive the response from the burst state.
    always_comb begin
        cmd_ready_o = !busy_q;
        rsp_valid_o = busy_q;
        rsp_last_o  = busy_q && at_last;
        rsp_error_o = busy_q && err_q;
        rsp_data_o  = (busy_q && !err_q) ? snap_q[idx_q] : '0;
    end

    // R9: a burst ends right after its last word
    p_last_ends_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last_o |=> !rsp_valid_o);

    // R9: words of one burst come on consecutive cycles
    p_burst_no_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_last_o) |=> rsp_valid_o);

    // R9: the snapshot does not move during a burst
    p_snapshot_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_last_o) |=> $stable(snap_q));

    // R10: an error answer is one zero word
    p_error_single_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error_o |-> (rsp_last_o && rsp_data_o == '0));
endmodule

// File: rtl/seu_timing_stats.sv
// Module: seu_timing_stats (top)
// Times scrub cycle, detect, correct, poll interval, pin overhead and
// inject-to-detect, and serves them over a sector-addressed mailbox.
// Assumes: all strobes are one cycle wide and synchronous to clk; the error
// pin level is already synchronised.
module seu_timing_stats
    import seu_stats_pkg::*;
#(
    parameter int                       CNT_W       = 32,
    parameter int                       SECTOR_W    = 4,
    parameter logic [(2**SECTOR_W)-1:0] SECTOR_MASK = 16'h0009
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_start_i,
    input  logic             det_start_i,
    input  logic             det_end_i,
    input  logic             cor_start_i,
    input  logic             cor_end_i,
    input  logic             inj_i,
    input  logic [1:0]       inj_mode_i,
    input  logic             poll_start_i,
    input  logic             err_found_i,
    input  logic             err_pin_i,
    input  logic             cmd_valid_i,
    input  logic [7:0]       cmd_opcode_i,
    input  logic [31:0]      cmd_param_i,
    output logic             cmd_ready_o,
    output logic             rsp_valid_o,
    output logic [CNT_W-1:0] rsp_data_o,
    output logic             rsp_last_o,
    output logic             rsp_error_o
);
    // Timer slots: 0 cycle, 1 detect, 2 correct, 3 poll, 4 pin overhead.
    localparam int               NUM_TIMERS   = 5;
    localparam logic [4:0]       PERIODIC_MAP = 5'b01001;
    localparam logic [4:0]       MARKER_MAP   = 5'b00100;

    logic                            pin_q;
    logic                            pin_toggle;
    logic [NUM_TIMERS-1:0]           t_start;
    logic [NUM_TIMERS-1:0]           t_stop;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] t_stat;
    logic [CNT_W-1:0]                inj_stat;
    logic [NUM_WORDS-1:0][CNT_W-1:0] stats;

    // Remember the previous pin level to spot a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= err_pin_i;
        end
    end

    assign pin_toggle = err_pin_i ^ pin_q;

    // Route each timer's start and stop strobes.
    always_comb begin
        t_start = {err_found_i, poll_start_i, cor_start_i, det_start_i, cycle_start_i};
        t_stop  = {pin_toggle,  1'b0,         cor_end_i,   det_end_i,   1'b0};
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TIMERS; gi++) begin : g_timer
            seu_span_timer #(
                .CNT_W    (CNT_W),
                .PERIODIC (PERIODIC_MAP[gi]),
                .RST_VAL  (MARKER_MAP[gi] ? {CNT_W{1'b1}} : {CNT_W{1'b0}})
            ) u_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .start_i (t_start[gi]),
                .stop_i  (t_stop[gi]),
                .stat_o  (t_stat[gi])
            );
        end
    endgenerate

    seu_inject_tracker #(
        .CNT_W (CNT_W)
    ) u_inject (
        .clk        (clk),
        .rst_n      (rst_n),
        .inj_i      (inj_i),
        .inj_mode_i (inj_mode_i),
        .det_end_i  (det_end_i),
        .stat_o     (inj_stat)
    );

    // Place the statistics in response order.
    always_comb begin
        stats[0] = t_stat[0];
        stats[1] = t_stat[1];
        stats[2] = t_stat[2];
        stats[3] = inj_stat;
        stats[4] = t_stat[3];
        stats[5] = t_stat[4];
    end

    seu_stats_mailbox #(
        .CNT_W       (CNT_W),
        .SECTOR_W    (SECTOR_W),
        .SECTOR_MASK (SECTOR_MASK)
    ) u_mailbox (
        .clk          (clk),
        .rst_n        (rst_n),
        .stats_i      (stats),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_opcode_i (cmd_opcode_i),
        .cmd_param_i  (cmd_param_i),
        .cmd_ready_o  (cmd_ready_o),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_data_o   (rsp_data_o),
        .rsp_last_o   (rsp_last_o),
        .rsp_error_o  (rsp_error_o)
    );

    // R10: an accepted command with a foreign opcode yields an error word next cycle
    p_bad_opcode_errors_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o && cmd_opcode_i != OPC_READ_STATS) |=> (rsp_valid_o && rsp_error_o));
endmodule

// File: tb/seu_timing_stats_tb.sv
// Bench: seu_timing_stats_tb_top
// Directed corner cases plus seeded random scrub/poll/inject sequences. The
// expected statistics come from a tick-stamped event model.
module seu_timing_stats_tb_top;
    localparam int          CNT_W  = 10;
    localparam int          MAXV   = (1 << CNT_W) - 2;
    localparam logic [CNT_W-1:0] MARK = '1;

    localparam int EV_CYC = 0, EV_DS = 1, EV_DE = 2, EV_CS = 3, EV_CE = 4;
    localparam int EV_INJ = 5, EV_POLL = 6, EV_FOUND = 7, EV_TOG = 8, EV_NONE = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cycle_start, det_start, det_end, cor_start, cor_end;
    logic             inj, poll_start, err_found, err_pin;
    logic [1:0]       inj_mode;
    logic             cmd_valid;
    logic [7:0]       cmd_opcode;
    logic [31:0]      cmd_param;
    logic             cmd_ready, rsp_valid, rsp_last, rsp_error;
    logic [CNT_W-1:0] rsp_data;

    int               vectors = 0;
    int               miscompares = 0;
    int               tick = 0;
    bit               finished = 1'b0;

    // model state
    logic [CNT_W-1:0] mdl [6];
    int  cyc_t, ds_t, cs_t, poll_t, found_t, inj_t, inj_need;
    bit  cyc_seen, ds_on, cs_on, poll_seen, found_on;

    always #10 clk = ~clk;

    always @(posedge clk) tick <= tick + 1;

    seu_timing_stats #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cycle_start_i(cycle_start), .det_start_i(det_start), .det_end_i(det_end),
        .cor_start_i(cor_start), .cor_end_i(cor_end), .inj_i(inj), .inj_mode_i(inj_mode),
        .poll_start_i(poll_start), .err_found_i(err_found), .err_pin_i(err_pin),
        .cmd_valid_i(cmd_valid), .cmd_opcode_i(cmd_opcode), .cmd_param_i(cmd_param),
        .cmd_ready_o(cmd_ready), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .rsp_last_o(rsp_last), .rsp_error_o(rsp_error)
    );

    function automatic logic [CNT_W-1:0] satf(input int n);
        return (n > MAXV) ? MAXV[CNT_W-1:0] : n[CNT_W-1:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic model_reset();
        mdl[0] = '0; mdl[1] = '0; mdl[2] = MARK; mdl[3] = MARK; mdl[4] = '0; mdl[5] = '0;
        cyc_seen = 0; ds_on = 0; cs_on = 0; poll_seen = 0; found_on = 0; inj_need = 0;
    endtask

    // Drive one strobe for one cycle (from a negedge), update the model, then idle gap cycles.
    task automatic step(input int ev, input int gap);
        int t;
        t = tick + 1;
        cycle_start = (ev == EV_CYC); det_start = (ev == EV_DS); det_end = (ev == EV_DE);
        cor_start = (ev == EV_CS); cor_end = (ev == EV_CE); inj = (ev == EV_INJ);
        poll_start = (ev == EV_POLL); err_found = (ev == EV_FOUND);
        if (ev == EV_TOG) err_pin = ~err_pin;
        case (ev)
            EV_CYC:   begin if (cyc_seen) mdl[0] = satf(t - cyc_t); cyc_t = t; cyc_seen = 1; end
            EV_DS:    begin ds_t = t; ds_on = 1; end
            EV_DE:    begin
                          if (ds_on) begin mdl[1] = satf(t - ds_t); ds_on = 0; end
                          if (inj_need > 0) begin
                              inj_need--;
                              if (inj_need == 0) mdl[3] = satf(t - inj_t);
                          end
                      end
            EV_CS:    begin cs_t = t; cs_on = 1; end
            EV_CE:    begin if (cs_on) begin mdl[2] = satf(t - cs_t); cs_on = 0; end end
            EV_INJ:   begin
                          if (inj_mode == 2'b01 || inj_mode == 2'b10) begin
                              inj_t = t; inj_need = (inj_mode == 2'b01) ? 1 : 2;
                          end
                      end
            EV_POLL:  begin if (poll_seen) mdl[4] = satf(t - poll_t); poll_t = t; poll_seen = 1; end
            EV_FOUND: begin found_t = t; found_on = 1; end
            EV_TOG:   begin if (found_on) begin mdl[5] = satf(t - found_t); found_on = 0; end end
            default: ;
        endcase
        @(negedge clk);
        cycle_start = 0; det_start = 0; det_end = 0; cor_start = 0; cor_end = 0;
        inj = 0; poll_start = 0; err_found = 0;
        repeat (gap) @(negedge clk);
    endtask

    // Issue a command and compare the response word by word.
    task automatic read_stats(input logic [7:0] opc, input logic [31:0] param,
                              input bit expect_ok, input string req);
        cmd_valid = 1'b1; cmd_opcode = opc; cmd_param = param;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (expect_ok) begin
            for (int w = 0; w < 6; w++) begin
                check($sformatf("%s word%0d", req, w),
                      {19'd0, rsp_valid, rsp_last, rsp_error, rsp_data},
                      {19'd0, 1'b1, (w == 5), 1'b0, mdl[w]});
                if (w == 0) check("R9 ready low while sending", {31'd0, cmd_ready}, 32'd0);
                if (w < 5) @(negedge clk);
            end
        end else begin
            check({req, " error word"}, {19'd0, rsp_valid, rsp_last, rsp_error, rsp_data},
                  {19'd0, 1'b1, 1'b1, 1'b1, {CNT_W{1'b0}}});
        end
        @(negedge clk);
        check({req, " burst over"}, {30'd0, rsp_valid, cmd_ready}, 32'd1);
    endtask

    function automatic int gap_r();
        return $urandom_range(0, 25);
    endfunction

    initial begin
        cycle_start = 0; det_start = 0; det_end = 0; cor_start = 0; cor_end = 0;
        inj = 0; inj_mode = 2'b00; poll_start = 0; err_found = 0; err_pin = 0;
        cmd_valid = 0; cmd_opcode = 0; cmd_param = 0;
        void'($urandom(32'd20240517));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset values, idle mailbox
        check("R8 idle after reset", {30'd0, rsp_valid, cmd_ready}, 32'd1);
        read_stats(8'h40, 32'h0003_0000, 1'b1, "R8 reset values");

        // R11: end strobes without a start change nothing
        step(EV_DE, 2); step(EV_CE, 2); step(EV_TOG, 2);
        read_stats(8'h40, 32'h0003_0000, 1'b1, "R11 orphan ends");

        // R4: invalid injection options are ignored
        inj_mode = 2'b00; step(EV_INJ, 3);
        inj_mode = 2'b11; step(EV_INJ, 3);
        step(EV_DS, 4); step(EV_DE, 1); step(EV_DS, 2); step(EV_DE, 1);
        read_stats(8'h40, 32'h0003_0000, 1'b1, "R4 ignored option / R2 detect");

        // R4: best and worst case injection options
        inj_mode = 2'b01; step(EV_INJ, 5); step(EV_DS, 3); step(EV_DE, 2);
        read_stats(8'h40, 32'h0003_0000, 1'b1, "R4 best case");
        inj_mode = 2'b10; step(EV_INJ, 2); step(EV_DS, 1); step(EV_DE, 4);
        step(EV_DS, 6); step(EV_DE, 2);
        read_stats(8'h40, 32'h0003_0000, 1'b1, "R4 worst case");

        // R7: saturation one below the marker
        step(EV_DS, 1100); step(EV_DE, 1);
        step(EV_POLL, 1200); step(EV_POLL, 1);
        read_stats(8'h40, 32'h0003_0000, 1'b1, "R7 saturation");

        // R10: foreign opcode and unmonitored sector; R9: other monitored sector
        read_stats(8'h41, 32'h0003_0000, 1'b0, "R10 bad opcode");
        read_stats(8'h40, 32'h0005_0000, 1'b0, "R10 unmonitored sector");
        read_stats(8'h40, 32'h0000_0000, 1'b1, "R9 sector 0");

        // R1 R2 R3 R5 R6: random scrub and poll sequences
        for (int r = 0; r < 20; r++) begin
            inj_mode = ($urandom_range(0, 3) == 0) ? 2'b00 : 2'($urandom_range(1, 2));
            step(EV_INJ, gap_r());
            step(EV_CYC, gap_r());
            step(EV_DS, gap_r());
            step(EV_DE, gap_r());
            if ($urandom_range(0, 1) == 1) begin
                step(EV_CS, gap_r());
                step(EV_CE, gap_r());
            end
            step(EV_CYC, gap_r());
            step(EV_DS, gap_r());
            step(EV_DE, gap_r());
            step(EV_POLL, gap_r());
            step(EV_FOUND, gap_r());
            step(EV_TOG, gap_r());
            step(EV_POLL, gap_r());
            read_stats(8'h40, 32'h0003_0000, 1'b1, "R1 R2 R3 R4 R5 R6 random round");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule